// File: doc/BRIEF.md
# I2C Register Write Master

This block is a single-master serial-bus controller that performs one register-style write to a byte-addressed slave, such as a serial memory. A command carries a 3-bit device select, a register address byte and a data byte. The block sends a start condition and then three bytes: the device address with the write bit, the register address and the data. It checks the slave's acknowledge after each byte and closes with a stop condition. A missing acknowledge on any byte aborts the rest of the transfer.

SCL and SDA are open-drain. The block only pulls a line low, through an output-enable, and it reads the real line levels back on `scl_in` and `sda_in`. A programmable divider sets the serial clock. Each bit period is split into four quarter phases of `QDIV` system clocks each.

The command port uses valid/ready. `cmd_ready` is high only while the block is idle and both bus lines read high. While `cmd_ready` is low, the source must hold `cmd_valid` and the command fields steady. The fields are captured in the cycle where `cmd_valid` and `cmd_ready` are both high. Once that handshake has happened, the fields may change at once, and the next command may already be offered.

Top module: `i2c_regwr_master`

## Requirements
- R1: `cmd_ready` is high only when the block is idle and both `scl_in` and `sda_in` are high. A handshake starts a transfer, and `busy` is high from the next cycle until the transfer ends.
- R2: Each transfer begins with exactly one start condition: SDA falls while SCL is high, and SCL falls afterwards.
- R3: The first byte is {TYPE_ID[3:0], cmd_sel[2:0], 0}. TYPE_ID is a parameter with default 4'b1010, and bit 0 = 0 marks a write.
- R4: The bytes are sent MSB first in the order device address, register address, data. Each byte is followed by a ninth clock during which the master does not pull SDA (`sda_oe` = 0).
- R5: Apart from the start and stop conditions, SDA changes only while SCL is low.
- R6: If SDA reads high at the ninth clock of any byte, no further byte is sent, a stop follows, and `nack_error` pulses for exactly one cycle with no `done`.
- R7: When all three bytes are acknowledged, a stop follows and `done` pulses for exactly one cycle.
- R8: A stop condition releases SCL first and then SDA while SCL is high. When `busy` falls, both output-enables are low.
- R9: A bit period lasts 4*QDIV system clocks, with SCL released for 2*QDIV of them.
- R10: A command held valid is accepted in the very cycle in which `done` pulses, giving back-to-back transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (idle and bus free) |
| cmd_sel | input | 3 | Device select bits placed in the address byte |
| cmd_reg | input | 8 | Register address byte |
| cmd_data | input | 8 | Data byte to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse: write completed with all acknowledges |
| nack_error | output | 1 | One-cycle pulse: transfer aborted on a not-acknowledge |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
Two functions can meet in one cycle: the completion pulse of one transfer and the acceptance of the next command. `done` rises in the same cycle that the block returns to idle with the bus released, so a held command can be taken at that edge. The bench keeps `cmd_valid` high across the end of a transfer and checks that `done` and `cmd_ready` are high together. It then checks that `busy` is high in the following cycle and that the second transfer's bytes arrive intact. A slave model on the simulated open-drain lines decodes the bytes and the start and stop events and measures the SCL timing. It also withholds acknowledges at chosen bytes, and the bench checks the abort against expected byte counts.

// File: rtl/i2c_regwr_pkg.sv
package i2c_regwr_pkg;
  localparam int BYTE_W  = 8;
  localparam int NBYTES  = 3;
  localparam int FRAME_W = BYTE_W * NBYTES;
  localparam int BIDX_W  = $clog2(BYTE_W);
  localparam int NIDX_W  = $clog2(NBYTES);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_ACK,
    ST_STOP
  } wr_state_e;
endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int QDIV = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clear || tick)  cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  generate
    if (QDIV > 1) begin : g_spacing
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R9
    end
  endgenerate
endmodule

// File: rtl/i2c_line_drv.sv
module i2c_line_drv
  import i2c_regwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  wr_state_e st_i,
  input  logic [1:0] phase_i,
  input  logic      bit_i,
  output logic      scl_oe,
  output logic      sda_oe
);
  logic scl_lv, sda_lv;

  // quarter-phase wave shapes; a 1 means the line is released
  always_comb begin
    scl_lv = 1'b1;
    sda_lv = 1'b1;
    case (st_i)
      ST_START: begin
        scl_lv = (phase_i != 2'd3);
        sda_lv = (phase_i < 2'd2);
      end
      ST_BIT: begin
        scl_lv = (phase_i == 2'd1) || (phase_i == 2'd2);
        sda_lv = bit_i;
      end
      ST_ACK: begin
        scl_lv = (phase_i == 2'd1) || (phase_i == 2'd2);
        sda_lv = 1'b1;
      end
      ST_STOP: begin
        scl_lv = (phase_i != 2'd0);
        sda_lv = (phase_i >= 2'd2);
      end
      default: begin
        scl_lv = 1'b1;
        sda_lv = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      scl_oe <= !scl_lv;
      sda_oe <= !sda_lv;
    end
  end

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> ($past(st_i) == ST_START || $past(st_i) == ST_STOP)); // R5
endmodule

// File: rtl/i2c_wr_seq.sv
module i2c_wr_seq
  import i2c_regwr_pkg::*;
#(
  parameter logic [3:0] TYPE_ID = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_sel,
  input  logic [BYTE_W-1:0] cmd_reg,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              accept,
  output wr_state_e         st_o,
  output logic [1:0]        phase_o,
  output logic              bit_o,
  output logic              busy,
  output logic              done,
  output logic              nack_error
);
  localparam logic [NIDX_W-1:0] LAST_BYTE = NIDX_W'(NBYTES - 1);
  localparam logic [BIDX_W-1:0] TOP_BIT   = BIDX_W'(BYTE_W - 1);

  wr_state_e          st;
  logic [1:0]         phase;
  logic [NIDX_W-1:0]  byte_idx;
  logic [BIDX_W-1:0]  bit_idx;
  logic [FRAME_W-1:0] shreg;
  logic               ack_bad;
  logic               nacked;
  logic               done_q, nack_q;

  assign cmd_ready  = (st == ST_IDLE) && scl_in && sda_in;
  assign accept     = cmd_valid && cmd_ready;
  assign st_o       = st;
  assign phase_o    = phase;
  assign bit_o      = shreg[FRAME_W-1];
  assign busy       = (st != ST_IDLE);
  assign done       = done_q;
  assign nack_error = nack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      phase    <= 2'd0;
      byte_idx <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      ack_bad  <= 1'b0;
      nacked   <= 1'b0;
      done_q   <= 1'b0;
      nack_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      nack_q <= 1'b0;
      if (accept) begin
        st       <= ST_START;
        phase    <= 2'd0;
        byte_idx <= '0;
        bit_idx  <= TOP_BIT;
        shreg    <= {TYPE_ID, cmd_sel, 1'b0, cmd_reg, cmd_data};
        ack_bad  <= 1'b0;
        nacked   <= 1'b0;
      end else if (tick && st != ST_IDLE) begin
        if (st == ST_ACK && phase == 2'd2) ack_bad <= sda_in;
        if (phase != 2'd3) begin
          phase <= phase + 2'd1;
        end else begin
          phase <= 2'd0;
          case (st)
            ST_START: st <= ST_BIT;
            ST_BIT: begin
              shreg <= {shreg[FRAME_W-2:0], 1'b0};
              if (bit_idx == '0) st <= ST_ACK;
              else               bit_idx <= bit_idx - 1'b1;
            end
            ST_ACK: begin
              if (ack_bad) begin
                nacked <= 1'b1;
                st     <= ST_STOP;
              end else if (byte_idx == LAST_BYTE) begin
                st <= ST_STOP;
              end else begin
                byte_idx <= byte_idx + 1'b1;
                bit_idx  <= TOP_BIT;
                st       <= ST_BIT;
              end
            end
            ST_STOP: begin
              st     <= ST_IDLE;
              done_q <= !nacked;
              nack_q <= nacked;
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end

  AST_START_FROM_FREE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(scl_in && sda_in)); // R1
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_NACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    nack_error |=> !nack_error); // R6
  AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && nack_error)); // R6
endmodule

// File: rtl/i2c_regwr_master.sv
module i2c_regwr_master
  import i2c_regwr_pkg::*;
#(
  parameter int         QDIV    = 31,
  parameter logic [3:0] TYPE_ID = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [2:0] cmd_sel,
  input  logic [7:0] cmd_reg,
  input  logic [7:0] cmd_data,
  output logic       busy,
  output logic       done,
  output logic       nack_error,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  logic       tick, accept, bit_val;
  logic [1:0] phase;
  wr_state_e  st;

  i2c_qtick #(.QDIV(QDIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clear(accept), .tick(tick)
  );

  i2c_wr_seq #(.TYPE_ID(TYPE_ID)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_sel(cmd_sel), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
    .scl_in(scl_in), .sda_in(sda_in),
    .accept(accept), .st_o(st), .phase_o(phase), .bit_o(bit_val),
    .busy(busy), .done(done), .nack_error(nack_error)
  );

  i2c_line_drv u_drv (
    .clk(clk), .rst_n(rst_n), .st_i(st), .phase_i(phase), .bit_i(bit_val),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  AST_RELEASED_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!scl_oe && !sda_oe)); // R8
endmodule

// File: tb/tb_i2c_regwr_master.sv
module tb_i2c_regwr_master;
  localparam int Q = 3;
  localparam logic [3:0] TID = 4'b1010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_sel = '0;
  logic [7:0] cmd_reg = '0, cmd_data = '0;
  logic       cmd_ready, busy, done, nack_error, scl_oe, sda_oe;
  logic       ext_sda_low = 1'b0;
  logic       slave_low = 1'b0;
  logic [2:0] ack_plan = 3'b111;

  wire scl_l = !scl_oe;
  wire sda_l = !(sda_oe || slave_low || ext_sda_low);

  i2c_regwr_master #(.QDIV(Q), .TYPE_ID(TID)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_sel(cmd_sel), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
    .busy(busy), .done(done), .nack_error(nack_error),
    .scl_in(scl_l), .sda_in(sda_l), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int total = 0, bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // slave model and bus monitor
  int   starts = 0, stops = 0, nbytes = 0, tbad = 0, ackdrv_bad = 0;
  logic [7:0] rx_mem [0:1023];
  logic [7:0] cur = '0;
  int   bitcnt = 0, bytecnt = 0, last_rise = 0;
  logic in_ack = 1'b0;
  logic scl_p = 1'b1, sda_p = 1'b1;

  always @(negedge clk) begin
    if (scl_l && scl_p && !sda_l && sda_p) begin
      starts  <= starts + 1;
      bitcnt  <= 0;
      bytecnt <= 0;
      in_ack  <= 1'b0;
    end
    if (scl_l && scl_p && sda_l && !sda_p) stops <= stops + 1;
    if (scl_l && !scl_p) begin
      if (!in_ack && bitcnt >= 1 && bitcnt < 8 && (cyc - last_rise) != 4*Q) tbad <= tbad + 1;
      last_rise <= cyc;
      if (!in_ack && bitcnt < 8) begin
        cur    <= {cur[6:0], sda_l};
        bitcnt <= bitcnt + 1;
      end
      if (in_ack && sda_oe) ackdrv_bad <= ackdrv_bad + 1;
    end
    if (!scl_l && scl_p) begin
      if (!in_ack && bitcnt >= 1 && (cyc - last_rise) != 2*Q) tbad <= tbad + 1;
      if (!in_ack && bitcnt == 8) begin
        in_ack    <= 1'b1;
        slave_low <= (bytecnt < 3) ? ack_plan[bytecnt] : 1'b0;
      end else if (in_ack) begin
        in_ack    <= 1'b0;
        slave_low <= 1'b0;
        rx_mem[nbytes % 1024] <= cur;
        nbytes  <= nbytes + 1;
        bytecnt <= bytecnt + 1;
        bitcnt  <= 0;
      end
    end
    scl_p <= scl_l;
    sda_p <= sda_l;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int i, input logic [2:0] s, input logic [7:0] r, input logic [7:0] d);
    if (i == 0) return {TID, s, 1'b0};
    if (i == 1) return r;
    return d;
  endfunction

  function automatic int exp_count(input logic [2:0] m);
    for (int i = 0; i < 3; i++) if (!m[i]) return i + 1;
    return 3;
  endfunction

  // waits for the end of a transfer; returns at the negedge where a result pulse is seen
  task automatic wait_result(output bit gd, output bit gn, output bit ok);
    ok = 1'b0; gd = 1'b0; gn = 1'b0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (done || nack_error) begin
        gd = done; gn = nack_error; ok = 1'b1;
        return;
      end
    end
  endtask

  task automatic run_write(input logic [2:0] s, input logic [7:0] r, input logic [7:0] d, input logic [2:0] m);
    int s0, p0, b0, t0, a0, n;
    bit gd, gn, ok, took;
    s0 = starts; p0 = stops; b0 = nbytes; t0 = tbad; a0 = ackdrv_bad;
    ack_plan = m;
    @(negedge clk);
    cmd_sel = s; cmd_reg = r; cmd_data = d; cmd_valid = 1'b1;
    took = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (cmd_ready) begin took = 1'b1; break; end
      @(negedge clk);
    end
    chk(took, "R1", "command accepted", took, 1);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R1", "busy after handshake", busy, 1);
    chk(cmd_ready == 1'b0, "R1", "ready low while busy", cmd_ready, 0);
    wait_result(gd, gn, ok);
    chk(ok, "R7", "transfer finished", ok, 1);
    chk(gd == (m == 3'b111), "R7", "done pulse", gd, (m == 3'b111));
    chk(gn == (m != 3'b111), "R6", "nack_error pulse", gn, (m != 3'b111));
    n = exp_count(m);
    chk((nbytes - b0) == n, "R6", "bytes on bus", nbytes - b0, n);
    for (int i = 0; i < 3; i++)
      if (i < n && i < (nbytes - b0))
        chk(rx_mem[(b0 + i) % 1024] == exp_byte(i, s, r, d), (i == 0) ? "R3" : "R4",
            "byte value", rx_mem[(b0 + i) % 1024], exp_byte(i, s, r, d));
    chk((starts - s0) == 1, "R2", "start count", starts - s0, 1);
    chk((stops - p0) == 1, "R8", "stop count", stops - p0, 1);
    chk((tbad - t0) == 0, "R9", "scl timing errors", tbad - t0, 0);
    chk((ackdrv_bad - a0) == 0, "R4", "master drove sda in ack", ackdrv_bad - a0, 0);
    chk(scl_l && sda_l && !busy, "R8", "bus free after stop", {scl_l, sda_l, busy}, 3'b110);
    @(negedge clk);
    chk(!done && !nack_error, "R6", "result pulse one cycle", {done, nack_error}, 0);
  endtask

  initial begin
    int seed_dummy;
    bit gd, gn, ok;
    logic [2:0] m;
    int s0, b0;
    seed_dummy = $urandom(32'd1357);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_oe && !sda_oe, "R8", "reset lines released", {scl_oe, sda_oe}, 0);
    chk(!busy && !done && !nack_error, "R1", "reset status", {busy, done, nack_error}, 0);
    chk(cmd_ready, "R1", "ready after reset", cmd_ready, 1);

    // bus held busy by another agent: no start allowed
    ext_sda_low = 1'b1;
    cmd_valid = 1'b1;
    repeat (20) @(negedge clk);
    chk(!cmd_ready && !busy, "R1", "no start on busy bus", {cmd_ready, busy}, 0);
    cmd_valid = 1'b0;
    ext_sda_low = 1'b0;
    @(negedge clk);

    // directed corners
    run_write(3'd0, 8'h00, 8'h00, 3'b111);
    run_write(3'd7, 8'hFF, 8'hFF, 3'b111);
    run_write(3'd5, 8'hA5, 8'h5A, 3'b110);  // R6 nack on address
    run_write(3'd2, 8'h3C, 8'hC3, 3'b101);  // R6 nack on register
    run_write(3'd6, 8'h81, 8'h7E, 3'b011);  // R6 nack on data byte

    // R10 back-to-back: command held valid across done
    ack_plan = 3'b111;
    s0 = starts; b0 = nbytes;
    @(negedge clk);
    cmd_sel = 3'd3; cmd_reg = 8'h12; cmd_data = 8'h34; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_sel = 3'd4; cmd_reg = 8'h56; cmd_data = 8'h78;
    wait_result(gd, gn, ok);
    chk(gd && cmd_ready, "R10", "done and ready together", {gd, cmd_ready}, 3);
    @(negedge clk);
    chk(busy == 1'b1, "R10", "second transfer started", busy, 1);
    cmd_valid = 1'b0;
    wait_result(gd, gn, ok);
    chk(gd, "R10", "second done", gd, 1);
    chk((nbytes - b0) == 6, "R10", "bytes of both", nbytes - b0, 6);
    chk(rx_mem[(b0 + 3) % 1024] == {TID, 3'd4, 1'b0}, "R10", "second address byte",
        rx_mem[(b0 + 3) % 1024], {TID, 3'd4, 1'b0});
    chk(rx_mem[(b0 + 5) % 1024] == 8'h78, "R10", "second data byte", rx_mem[(b0 + 5) % 1024], 8'h78);
    chk((starts - s0) == 2, "R2", "two starts", starts - s0, 2);
    repeat (3) @(negedge clk);

    // constrained random
    for (int t = 0; t < 30; t++) begin
      m = ($urandom % 4 == 0) ? 3'($urandom % 7) : 3'b111;
      run_write(3'($urandom), 8'($urandom), 8'($urandom), m);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule